// File: doc/BRIEF.md
# Six-Region Chip-Select Decoder

This block turns a 24-bit external memory address into six active-low chip-select lines. Each region has three registers: a base address, a compare mask and a configuration word. A region claims an address when the address bits under the mask equal the base bits under the mask. The configuration word of the region that claims the address gives the data bus width and the wait-state count for the cycle, and the block presents both alongside the select lines.

A bus controller raises the external-cycle strobe for the length of an external access. The decoder captures its result on the first clock edge that samples the strobe high. It holds that result while the strobe stays high and releases every select on the first edge that samples the strobe low. When no region claims the address, every select stays high and the bus settings come from the last region.

When reset is released, region 0 already covers the 256-byte boot window FF2000h to FF20FFh and every other region is disabled. Software can then reprogram the regions through a simple synchronous write port.

Top module: `csd_top`

## Requirements
- R1: While reset is asserted and on the first edge after it, every chip-select output is high, `bus16` is 0 and `wait_st` is 0.
- R2: A chip-select goes low only in a cycle captured while `ext_cyc` was high. The captured value appears on the outputs after the first rising clock edge that samples `ext_cyc` high following an edge that sampled it low.
- R3: Region i claims an address when its enable bit is set and `(addr ^ base_i) & mask_i == 0`. A mask bit of 1 means that address bit is compared.
- R4: When several enabled regions claim the same address, only the lowest-numbered of them drives its select low. At most one select is ever low.
- R5: When no enabled region claims the address, all selects stay high and `bus16` and `wait_st` take the width and wait fields of region 5.
- R6: After reset, region 0 has base FF2000h, mask FFFF00h, enable 1, width 8-bit and 3 wait states. Regions 1 to 5 have enable 0, width 8-bit and 3 wait states.
- R7: While `ext_cyc` stays high, `cs_n`, `bus16` and `wait_st` keep their captured values, even if `addr` changes or a register is written.
- R8: An edge that samples `ext_cyc` low drives every select high. `bus16` and `wait_st` keep their last values.
- R9: A register write takes effect from the next captured cycle onward. The cycle in progress is not affected.
- R10: The field code on `wr_fld` selects the target register: 0 = base, 1 = mask, 2 = configuration. A configuration write uses bit 0 of `wr_data` as the enable, bit 1 as the width (1 = 16-bit) and bits 3:2 as the wait count. A region with enable 0 never drives its select low.
- R11: A write with `wr_sel` of 6 or 7, or with field code 3, changes no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 24 | External memory address |
| ext_cyc | input | 1 | High for the length of an external memory cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Region index for the write |
| wr_fld | input | 2 | Field code: 0 base, 1 mask, 2 configuration |
| wr_data | input | 24 | Write data |
| cs_n | output | 6 | Active-low chip selects, bit i for region i |
| bus16 | output | 1 | 1 when the selected cycle uses a 16-bit bus |
| wait_st | output | 2 | Wait-state count for the selected cycle |

## Verification
The checker takes two things for granted. First, `ext_cyc` is low while reset is applied, so its own record of the last strobe value and the block's capture register agree from the first edge. Second, every external cycle is separated from the next by at least one edge that samples the strobe low, because a strobe that never drops would never start a new capture. The bench drives each access as a strobe-high phase followed by a strobe-low phase, holds the strobe low throughout reset, and makes all writes between captures or inside a held cycle.

// File: rtl/csd_pkg.sv
// Package csd_pkg
// Shared types for the chip-select decoder: the per-region configuration
// word and the field codes used on the register write port.
package csd_pkg;

    localparam int CSD_WAIT_W = 2;

    // Per-region bus settings plus the region enable.
    typedef struct packed {
        logic [CSD_WAIT_W-1:0] waits;
        logic                  wide;
        logic                  enable;
    } region_cfg_t;

    localparam int CSD_CFG_W = $bits(region_cfg_t);

    // Field codes on the write port.
    localparam logic [1:0] FLD_BASE = 2'd0;
    localparam logic [1:0] FLD_MASK = 2'd1;
    localparam logic [1:0] FLD_CFG  = 2'd2;

endpackage

// File: rtl/csd_regfile.sv
// Module csd_regfile
// Holds base, mask and configuration for every region. Region 0 resets to
// the boot window and is enabled; all other regions reset disabled.
// Assumes: writes are single-cycle pulses. An index at or above NUM_REGIONS,
// or an unused field code, matches no region and is dropped.
module csd_regfile
    import csd_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          NUM_REGIONS = 6,
    parameter int          SEL_W       = 3,
    parameter logic [23:0] BOOT_BASE   = 24'hFF2000,
    parameter logic [23:0] BOOT_MASK   = 24'hFFFF00
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [SEL_W-1:0]                    wr_sel,
    input  logic [1:0]                          wr_fld,
    input  logic [ADDR_W-1:0]                   wr_data,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_q,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  mask_q,
    output region_cfg_t [NUM_REGIONS-1:0]       cfg_q
);

    localparam region_cfg_t IDLE_CFG = '{waits: '1, wide: 1'b0, enable: 1'b0};
    localparam region_cfg_t BOOT_CFG = '{waits: '1, wide: 1'b0, enable: 1'b1};

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        localparam bit IS_BOOT = (i == 0);
        logic hit_sel;
        assign hit_sel = wr_en && (wr_sel == SEL_W'(i));

        // Region storage: reset defaults, then field-addressed updates.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= IS_BOOT ? ADDR_W'(BOOT_BASE) : '0;
                mask_q[i] <= IS_BOOT ? ADDR_W'(BOOT_MASK) : '1;
                cfg_q[i]  <= IS_BOOT ? BOOT_CFG : IDLE_CFG;
            end else if (hit_sel) begin
                case (wr_fld)
                    FLD_BASE: base_q[i] <= wr_data;
                    FLD_MASK: mask_q[i] <= wr_data;
                    FLD_CFG:  cfg_q[i]  <= region_cfg_t'(wr_data[CSD_CFG_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csd_match.sv
// Module csd_match
// Compares the address against every region in parallel. A region hits when
// it is enabled and all compared (mask = 1) bits equal its base.
// Assumes: addr is stable while it is being decoded.
module csd_match
    import csd_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int NUM_REGIONS = 6
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_q,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  mask_q,
    input  region_cfg_t [NUM_REGIONS-1:0]       cfg_q,
    output logic [NUM_REGIONS-1:0]              hit
);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
        logic [ADDR_W-1:0] diff;
        // Per-region masked equality.
        always_comb begin
            diff   = (addr ^ base_q[i]) & mask_q[i];
            hit[i] = cfg_q[i].enable && (diff == '0);
        end
    end

endmodule

// File: rtl/csd_priority.sv
// Module csd_priority
// Reduces the raw hits to a single grant, the lowest-numbered hit winning,
// and picks that region's bus settings. With no hit the fallback settings
// (the last region's) are passed on.
// Assumes: nothing beyond the hit vector being combinational.
module csd_priority
    import csd_pkg::*;
#(
    parameter int NUM_REGIONS = 6
) (
    input  logic [NUM_REGIONS-1:0]          hit,
    input  region_cfg_t [NUM_REGIONS-1:0]   cfg_q,
    input  logic                            fb_wide,
    input  logic [CSD_WAIT_W-1:0]           fb_waits,
    output logic [NUM_REGIONS-1:0]          grant,
    output logic                            no_hit,
    output logic                            sel_wide,
    output logic [CSD_WAIT_W-1:0]           sel_waits
);

    logic [NUM_REGIONS:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_chain
        // Prefix chain: a region is granted only if no lower one hit.
        assign grant[i]       = hit[i] && !blocked[i];
        assign blocked[i + 1] = blocked[i] || hit[i];
    end

    assign no_hit = !blocked[NUM_REGIONS];

    // Settings multiplexer driven by the one-hot grant.
    always_comb begin
        sel_wide  = fb_wide;
        sel_waits = fb_waits;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (grant[i]) begin
                sel_wide  = cfg_q[i].wide;
                sel_waits = cfg_q[i].waits;
            end
        end
    end

endmodule

// File: rtl/csd_top.sv
// Module csd_top
// Six-region chip-select decoder. Captures the decode on the first edge of
// an external cycle, holds it while the strobe stays high and releases the
// selects when the strobe drops.
// Assumes: ext_cyc is low during reset and drops for at least one sampled
// edge between accesses.
module csd_top
    import csd_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          NUM_REGIONS = 6,
    parameter logic [23:0] BOOT_BASE   = 24'hFF2000,
    parameter logic [23:0] BOOT_MASK   = 24'hFFFF00,
    localparam int         SEL_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ext_cyc,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [1:0]              wr_fld,
    input  logic [ADDR_W-1:0]       wr_data,
    output logic [NUM_REGIONS-1:0]  cs_n,
    output logic                    bus16,
    output logic [CSD_WAIT_W-1:0]   wait_st
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] mask_q;
    region_cfg_t [NUM_REGIONS-1:0]      cfg_q;
    logic [NUM_REGIONS-1:0]             hit;
    logic [NUM_REGIONS-1:0]             grant;
    logic                               no_hit;
    logic                               sel_wide;
    logic [CSD_WAIT_W-1:0]              sel_waits;
    logic                               cyc_q;
    logic                               start;

    csd_regfile #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS),
        .SEL_W       (SEL_W),
        .BOOT_BASE   (BOOT_BASE),
        .BOOT_MASK   (BOOT_MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_fld  (wr_fld),
        .wr_data (wr_data),
        .base_q  (base_q),
        .mask_q  (mask_q),
        .cfg_q   (cfg_q)
    );

    csd_match #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS)
    ) u_match (
        .addr   (addr),
        .base_q (base_q),
        .mask_q (mask_q),
        .cfg_q  (cfg_q),
        .hit    (hit)
    );

    csd_priority #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_prio (
        .hit       (hit),
        .cfg_q     (cfg_q),
        .fb_wide   (cfg_q[NUM_REGIONS-1].wide),
        .fb_waits  (cfg_q[NUM_REGIONS-1].waits),
        .grant     (grant),
        .no_hit    (no_hit),
        .sel_wide  (sel_wide),
        .sel_waits (sel_waits)
    );

    assign start = ext_cyc && !cyc_q;

    // Remember the strobe level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= 1'b0;
        else        cyc_q <= ext_cyc;
    end

    // Output register: capture on cycle start, hold, release on strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n    <= '1;
            bus16   <= 1'b0;
            wait_st <= '0;
        end else if (start) begin
            cs_n    <= ~grant;
            bus16   <= sel_wide;
            wait_st <= sel_waits;
        end else if (!ext_cyc) begin
            cs_n    <= '1;
        end
    end

endmodule

// File: rtl/csd_checker.sv
// Module csd_checker
// Protocol properties of the decoder outputs. Keeps its own record of the
// previous strobe level so that it does not reuse the design's register.
// Assumes: ext_cyc is low during reset.
module csd_checker
    import csd_pkg::*;
#(
    parameter int NUM_REGIONS = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ext_cyc,
    input logic [NUM_REGIONS-1:0]  cs_n,
    input logic                    bus16,
    input logic [CSD_WAIT_W-1:0]   wait_st,
    input logic                    no_hit,
    input logic                    fb_wide,
    input logic [CSD_WAIT_W-1:0]   fb_waits
);

    logic seen_cyc;

    // Track the strobe independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_cyc <= 1'b0;
        else        seen_cyc <= ext_cyc;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R4

    AST_SELECT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> seen_cyc); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cyc && seen_cyc) |=> ($stable(cs_n) && $stable(bus16) && $stable(wait_st))); // R7

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cyc |=> (&cs_n)); // R8

    AST_MISS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cyc && !seen_cyc && no_hit) |=>
            ((&cs_n) && bus16 == $past(fb_wide) && wait_st == $past(fb_waits))); // R5

endmodule

bind csd_top csd_checker #(
    .NUM_REGIONS (NUM_REGIONS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_cyc  (ext_cyc),
    .cs_n     (cs_n),
    .bus16    (bus16),
    .wait_st  (wait_st),
    .no_hit   (no_hit),
    .fb_wide  (cfg_q[NUM_REGIONS-1].wide),
    .fb_waits (cfg_q[NUM_REGIONS-1].waits)
);

// File: tb/csd_top_test.sv
`timescale 1ns/1ps
// Bench for csd_top: address sweeps across several region programs, with a
// behavioural model of the region registers for the expected values.
module csd_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        ext_cyc = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [1:0]  wr_fld = '0;
    logic [23:0] wr_data = '0;
    logic [5:0]  cs_n;
    logic        bus16;
    logic [1:0]  wait_st;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state.
    logic [23:0] m_base [6];
    logic [23:0] m_mask [6];
    logic        m_en   [6];
    logic        m_wide [6];
    logic [1:0]  m_wait [6];

    always #4 clk = ~clk;

    csd_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .ext_cyc (ext_cyc),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_fld  (wr_fld),
        .wr_data (wr_data),
        .cs_n    (cs_n),
        .bus16   (bus16),
        .wait_st (wait_st)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {cs_n, bus16, wait_st} for an address under the model.
    function automatic logic [8:0] model(input logic [23:0] a, output bit miss);
        logic [5:0] cs = 6'h3F;
        logic       w  = m_wide[5];
        logic [1:0] ws = m_wait[5];
        miss = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (miss && m_en[i] && (((a ^ m_base[i]) & m_mask[i]) == 24'h0)) begin
                miss  = 1'b0;
                cs[i] = 1'b0;
                w     = m_wide[i];
                ws    = m_wait[i];
            end
        end
        return {cs, w, ws};
    endfunction

    task automatic reg_write(input logic [2:0] sel, input logic [1:0] fld, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_fld = fld; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel < 3'd6) begin
            case (fld)
                2'd0: m_base[sel] = d;
                2'd1: m_mask[sel] = d;
                2'd2: begin m_en[sel] = d[0]; m_wide[sel] = d[1]; m_wait[sel] = d[3:2]; end
                default: ;
            endcase
        end
    endtask

    // One external access: capture, hold with a changed address, release.
    task automatic access(input logic [23:0] a, input string tag);
        logic [8:0] exp;
        bit         miss;
        exp = model(a, miss);
        @(negedge clk);
        addr = a; ext_cyc = 1'b1;
        @(negedge clk);
        chk(miss ? {tag, " R5 miss"} : {tag, " R2/R3/R4 decode"}, {cs_n, bus16, wait_st}, exp);
        addr = ~a;
        @(negedge clk);
        chk("R7 hold", {cs_n, bus16, wait_st}, exp);
        ext_cyc = 1'b0;
        @(negedge clk);
        chk("R8 release", {cs_n, bus16, wait_st}, {6'h3F, exp[2:0]});
    endtask

    task automatic sweep(input string tag);
        logic [15:0] lows [5] = '{16'h2000, 16'h20FF, 16'h2100, 16'h0000, 16'h1FFF};
        for (int hi = 0; hi < 256; hi++) begin
            for (int k = 0; k < 5; k++) begin
                access({hi[7:0], lows[k]}, tag);
            end
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] held;
        bit         miss;
        // Reset model values (R6).
        for (int i = 0; i < 6; i++) begin
            m_base[i] = 24'h0; m_mask[i] = 24'hFFFFFF;
            m_en[i] = 1'b0; m_wide[i] = 1'b0; m_wait[i] = 2'd3;
        end
        m_base[0] = 24'hFF2000; m_mask[0] = 24'hFFFF00; m_en[0] = 1'b1;

        repeat (3) @(negedge clk);
        chk("R1 in reset", {cs_n, bus16, wait_st}, 9'h1F8);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {cs_n, bus16, wait_st}, 9'h1F8);

        // Boot window only (R6): FF2000..FF20FF hits region 0.
        access(24'hFF2000, "R6 boot low");
        access(24'hFF20FF, "R6 boot high");
        access(24'hFF2100, "R6 above boot");
        access(24'hFF1FFF, "R6 below boot");
        sweep("R6 reset map");

        // Program overlapping regions and a distinct fallback.
        reg_write(3'd1, 2'd0, 24'h100000); reg_write(3'd1, 2'd1, 24'hF00000);
        reg_write(3'd1, 2'd2, 24'h3);      // enabled, 16-bit, 0 waits
        reg_write(3'd2, 2'd0, 24'h180000); reg_write(3'd2, 2'd1, 24'hF80000);
        reg_write(3'd2, 2'd2, 24'h5);      // enabled, 8-bit, 1 wait
        reg_write(3'd3, 2'd0, 24'h800000); reg_write(3'd3, 2'd1, 24'hC00000);
        reg_write(3'd3, 2'd2, 24'hB);      // enabled, 16-bit, 2 waits
        reg_write(3'd4, 2'd1, 24'h000000); // matches all but disabled (R10)
        reg_write(3'd4, 2'd2, 24'h6);
        reg_write(3'd5, 2'd0, 24'hFE0000); reg_write(3'd5, 2'd1, 24'hFF0000);
        reg_write(3'd5, 2'd2, 24'h7);      // enabled, 16-bit, 1 wait
        access(24'h180000, "R4 overlap 1 over 2");
        access(24'h000123, "R10 disabled catch-all");
        access(24'hFE8000, "R3 region 5");
        sweep("R3 programmed map");

        // Enable the catch-all; regions 0..3 still outrank it (R4, R10).
        reg_write(3'd4, 2'd2, 24'h9);
        sweep("R4 catch-all");
        reg_write(3'd4, 2'd2, 24'h0);

        // Ignored writes (R11): bad index and field code 3.
        reg_write(3'd6, 2'd2, 24'h1);
        reg_write(3'd7, 2'd1, 24'h000000);
        reg_write(3'd1, 2'd3, 24'hFFFFFF);
        access(24'h100000, "R11 ignored writes r1");
        access(24'h400000, "R11 ignored writes miss");

        // Write during a held cycle (R9): current cycle unchanged, next one updated.
        held = model(24'h100040, miss);
        @(negedge clk);
        addr = 24'h100040; ext_cyc = 1'b1;
        @(negedge clk);
        chk("R9 capture", {cs_n, bus16, wait_st}, held);
        wr_en = 1'b1; wr_sel = 3'd1; wr_fld = 2'd2; wr_data = 24'hD;
        @(negedge clk);
        wr_en = 1'b0;
        m_en[1] = 1'b1; m_wide[1] = 1'b0; m_wait[1] = 2'd3;
        chk("R9 same cycle kept", {cs_n, bus16, wait_st}, held);
        ext_cyc = 1'b0;
        @(negedge clk);
        access(24'h100040, "R9 next cycle");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule